// File: doc/BRIEF.md
# Legacy display address routing decoder

This block sits beside a downstream graphics port and decides, for each memory or I/O request issued by the processor, whether the port claims it or whether it stays on the internal backbone. It only routes addresses that belong to the legacy display windows: the VGA frame buffer and register ranges, and the monochrome (MDA) frame buffer and register locations. A request is presented for one cycle with a valid strobe, a memory/I/O flag, a dword address and byte enables. The claim decision comes out of a register one clock later.

The port's configuration arrives as live inputs: a VGA enable, memory-access and I/O-access enables, and a 4 KB-granular I/O base/limit window. The monochrome-present bit is held in a small register inside the block, written through a strobe and read back on a port. When it is set, the monochrome ranges are removed from what the port claims for VGA. An I/O request that touches any monochrome byte then stays on the backbone, even if its other bytes lie outside those locations. Monochrome set with VGA disabled is an illegal setting. The block claims nothing in that state and raises a registered error flag.

Top module: `legacy_disp_router`

## Requirements
- R1: With VGA enable 1, memory enable 1 and monochrome-present 0, a memory request with at least one byte enable set is claimed exactly when its address lies in 0A0000h..0BFFFFh; any address outside that range is never claimed.
- R2: With monochrome-present 1 (and VGA enable 1, memory enable 1), memory requests in 0B0000h..0B7FFFh are not claimed, while the rest of 0A0000h..0BFFFFh is still claimed.
- R3: With VGA enable 1 and I/O enable 1, an I/O request whose enabled bytes hit 3B0h..3BBh or 3C0h..3DFh is claimed, unless R4 applies. Address bits [15:10] are ignored, so every alias of these ranges matches. Byte lane i of a request at dword address A is byte address A+i, where lane 0 is req_be bit 0.
- R4: With monochrome-present 1, an I/O request whose enabled bytes include any of 3B4h, 3B5h, 3B8h, 3B9h, 3BAh, 3BFh (or their aliases) is not claimed, even when other enabled bytes are VGA locations.
- R5: I/O bytes 3BCh..3BFh (3BFh only while monochrome-present is 0) are claimed only when address bits [15:12] lie within io_base..io_limit inclusive; outside the window they stay on the backbone.
- R6: With VGA enable 0 nothing is claimed. VGA enable 0 together with monochrome-present 1 sets cfg_err one cycle later, and cfg_err is 0 in every other setting.
- R7: Memory requests are claimed only while mem_en is 1, and I/O requests only while io_en is 1.
- R8: The monochrome-present register resets to 0, takes mdap_wdata on the clock edge where mdap_wr is 1, and holds its value otherwise. A request in the same cycle as a write is decided with the old value.
- R9: claim_vld is 1 exactly one cycle after req_valid. claim is 0 whenever claim_vld is 0, and a request with all byte enables 0 is never claimed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_is_io | input | 1 | 1 = I/O request, 0 = memory request |
| req_addr | input | ADDR_W | Dword-aligned request address |
| req_be | input | LANES | Byte enables, lane 0 in bit 0 |
| vga_en | input | 1 | VGA routing enable of the port |
| mem_en | input | 1 | Memory access enable of the port |
| io_en | input | 1 | I/O access enable of the port |
| io_base | input | WIN_W | I/O window base, address bits [15:12] |
| io_limit | input | WIN_W | I/O window limit, address bits [15:12] |
| mdap_wr | input | 1 | Write strobe for the monochrome-present bit |
| mdap_wdata | input | 1 | Value to write |
| mdap_q | output | 1 | Current monochrome-present bit |
| claim_vld | output | 1 | Decision valid, one cycle after req_valid |
| claim | output | 1 | 1 = the port claims the request |
| cfg_err | output | 1 | Illegal setting flag (VGA off, monochrome on) |

## Verification
A write to the monochrome-present bit and a request that depends on it can arrive in the same cycle. The write lands on that edge, and the decision must still use the old value. The bench provokes this with random write strobes laid over random requests in the monochrome and VGA ranges, plus a directed case of a write together with a 0B0000h access. Each decision is judged against a reference model that applies the write only after it has scored the request. The illegal-setting flag follows the same order: it is checked against the register value from before the write.

// File: rtl/lgd_pkg.sv
package lgd_pkg;

  localparam logic [31:0] VGA_MEM_LO = 32'h000A_0000;
  localparam logic [31:0] VGA_MEM_HI = 32'h000B_FFFF;
  localparam logic [31:0] MDA_MEM_LO = 32'h000B_0000;
  localparam logic [31:0] MDA_MEM_HI = 32'h000B_7FFF;

  // 10-bit (alias-free) I/O classification
  function automatic logic io_is_vga(input logic [9:0] a);
    return ((a >= 10'h3B0) && (a <= 10'h3BB)) || ((a >= 10'h3C0) && (a <= 10'h3DF));
  endfunction

  function automatic logic io_is_mda(input logic [9:0] a);
    case (a)
      10'h3B4, 10'h3B5, 10'h3B8, 10'h3B9, 10'h3BA, 10'h3BF: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic io_is_hole(input logic [9:0] a);
    return (a >= 10'h3BC) && (a <= 10'h3BF);
  endfunction

endpackage

// File: rtl/lgd_mda_reg.sv
module lgd_mda_reg (
  input  logic clk,
  input  logic rst,
  input  logic wr,
  input  logic wdata,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= 1'b0;
    else if (wr) q <= wdata;
  end
endmodule

// File: rtl/lgd_mem_decode.sv
module lgd_mem_decode
  import lgd_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              in_vga,
  output logic              in_mda
);
  localparam logic [ADDR_W-1:0] V_LO = ADDR_W'(VGA_MEM_LO);
  localparam logic [ADDR_W-1:0] V_HI = ADDR_W'(VGA_MEM_HI);
  localparam logic [ADDR_W-1:0] M_LO = ADDR_W'(MDA_MEM_LO);
  localparam logic [ADDR_W-1:0] M_HI = ADDR_W'(MDA_MEM_HI);

  always_comb begin
    in_vga = (addr >= V_LO) && (addr <= V_HI);
    in_mda = (addr >= M_LO) && (addr <= M_HI);
  end
endmodule

// File: rtl/lgd_io_decode.sv
module lgd_io_decode
  import lgd_pkg::*;
#(
  parameter int LANES = 4,
  parameter int WIN_W = 4
) (
  input  logic [15:$clog2(LANES)] io_addr,
  input  logic [LANES-1:0]        be,
  input  logic [WIN_W-1:0]        win_base,
  input  logic [WIN_W-1:0]        win_limit,
  output logic                    any_vga,
  output logic                    any_mda,
  output logic                    any_hole,
  output logic                    in_window
);
  localparam int LANE_SH = $clog2(LANES);
  localparam int WIN_LO  = 16 - WIN_W;

  logic [LANES-1:0] hit_v, hit_m, hit_h;

  // one classifier per byte lane; bits [15:10] never enter the compare
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [9:0] lane_a;
    assign lane_a   = {io_addr[9:LANE_SH], LANE_SH'(i)};
    assign hit_v[i] = be[i] & io_is_vga(lane_a);
    assign hit_m[i] = be[i] & io_is_mda(lane_a);
    assign hit_h[i] = be[i] & io_is_hole(lane_a);
  end

  logic [WIN_W-1:0] win_key;
  assign win_key = io_addr[15:WIN_LO];

  always_comb begin
    any_vga   = |hit_v;
    any_mda   = |hit_m;
    any_hole  = |hit_h;
    in_window = (win_key >= win_base) && (win_key <= win_limit);
  end
endmodule

// File: rtl/legacy_disp_router.sv
module legacy_disp_router #(
  parameter int ADDR_W = 32,
  parameter int LANES  = 4,
  parameter int WIN_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_is_io,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LANES-1:0]  req_be,
  input  logic              vga_en,
  input  logic              mem_en,
  input  logic              io_en,
  input  logic [WIN_W-1:0]  io_base,
  input  logic [WIN_W-1:0]  io_limit,
  input  logic              mdap_wr,
  input  logic              mdap_wdata,
  output logic              mdap_q,
  output logic              claim_vld,
  output logic              claim,
  output logic              cfg_err
);
  localparam int LANE_SH = $clog2(LANES);

  logic mdap;
  logic io_vga, io_mda, io_hole, io_win;
  logic mem_vga, mem_mda;
  logic io_ok, mem_ok, decide, illegal;

  lgd_mda_reg u_mdap (
    .clk   (clk),
    .rst   (rst),
    .wr    (mdap_wr),
    .wdata (mdap_wdata),
    .q     (mdap)
  );

  lgd_io_decode #(.LANES(LANES), .WIN_W(WIN_W)) u_io (
    .io_addr   (req_addr[15:LANE_SH]),
    .be        (req_be),
    .win_base  (io_base),
    .win_limit (io_limit),
    .any_vga   (io_vga),
    .any_mda   (io_mda),
    .any_hole  (io_hole),
    .in_window (io_win)
  );

  lgd_mem_decode #(.ADDR_W(ADDR_W)) u_mem (
    .addr   (req_addr),
    .in_vga (mem_vga),
    .in_mda (mem_mda)
  );

  always_comb begin
    illegal = ~vga_en & mdap;
    io_ok   = io_en & vga_en & (|req_be) & (io_vga | (io_hole & io_win))
              & ~(mdap & io_mda);
    mem_ok  = mem_en & vga_en & (|req_be) & mem_vga & ~(mdap & mem_mda);
    decide  = req_is_io ? io_ok : mem_ok;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      claim_vld <= 1'b0;
      claim     <= 1'b0;
      cfg_err   <= 1'b0;
    end else begin
      claim_vld <= req_valid;
      claim     <= req_valid & decide;
      cfg_err   <= illegal;
    end
  end

  assign mdap_q = mdap;
endmodule

// File: rtl/lgd_route_chk.sv
module lgd_route_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_is_io,
  input logic [ADDR_W-1:0] req_addr,
  input logic              vga_en,
  input logic              mem_en,
  input logic              io_en,
  input logic              mdap_wr,
  input logic              mdap_wdata,
  input logic              mdap_q,
  input logic              claim_vld,
  input logic              claim,
  input logic              cfg_err
);
  logic in_mda_mem;
  assign in_mda_mem = (req_addr >= ADDR_W'(32'h000B_0000)) && (req_addr <= ADDR_W'(32'h000B_7FFF));

  p_vld_follows_r9: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> claim_vld);
  p_no_stray_claim_r9: assert property (@(posedge clk) disable iff (rst)
    !claim_vld |-> !claim);
  p_vga_off_r6: assert property (@(posedge clk) disable iff (rst)
    !vga_en |=> !claim);
  p_err_flag_r6: assert property (@(posedge clk) disable iff (rst)
    (!vga_en && mdap_q) |=> cfg_err);
  p_mem_gate_r7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_is_io && !mem_en) |=> !claim);
  p_io_gate_r7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_is_io && !io_en) |=> !claim);
  p_mda_mem_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_is_io && mdap_q && in_mda_mem) |=> !claim);
  p_mdap_write_r8: assert property (@(posedge clk) disable iff (rst)
    mdap_wr |=> (mdap_q == $past(mdap_wdata)));
  p_mdap_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !mdap_wr |=> $stable(mdap_q));
endmodule

bind legacy_disp_router lgd_route_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_is_io  (req_is_io),
  .req_addr   (req_addr),
  .vga_en     (vga_en),
  .mem_en     (mem_en),
  .io_en      (io_en),
  .mdap_wr    (mdap_wr),
  .mdap_wdata (mdap_wdata),
  .mdap_q     (mdap_q),
  .claim_vld  (claim_vld),
  .claim      (claim),
  .cfg_err    (cfg_err)
);

// File: tb/legacy_disp_router_tb_top.sv
`timescale 1ns/1ps
module legacy_disp_router_tb_top;
  localparam int ADDR_W = 32;
  localparam int LANES  = 4;
  localparam int WIN_W  = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_is_io = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [LANES-1:0] req_be = '0;
  logic vga_en = 1'b0, mem_en = 1'b0, io_en = 1'b0;
  logic [WIN_W-1:0] io_base = '0, io_limit = '0;
  logic mdap_wr = 1'b0, mdap_wdata = 1'b0;
  logic mdap_q, claim_vld, claim, cfg_err;

  always #2.5 clk = ~clk;

  legacy_disp_router #(.ADDR_W(ADDR_W), .LANES(LANES), .WIN_W(WIN_W)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_is_io(req_is_io),
    .req_addr(req_addr), .req_be(req_be), .vga_en(vga_en), .mem_en(mem_en),
    .io_en(io_en), .io_base(io_base), .io_limit(io_limit), .mdap_wr(mdap_wr),
    .mdap_wdata(mdap_wdata), .mdap_q(mdap_q), .claim_vld(claim_vld),
    .claim(claim), .cfg_err(cfg_err)
  );

  int n_chk = 0, n_bad = 0;
  bit model_mdap = 1'b0;
  bit finished = 1'b0;

  task automatic check(input bit act, input bit exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", what, act, exp);
    end
  endtask

  function automatic bit ref_mda_io(input logic [9:0] a);
    return a == 10'h3B4 || a == 10'h3B5 || a == 10'h3B8 ||
           a == 10'h3B9 || a == 10'h3BA || a == 10'h3BF;
  endfunction

  function automatic bit ref_claim(input bit io, input logic [31:0] a,
                                   input logic [3:0] be, input bit md);
    bit v = 0, m = 0, h = 0, w;
    if (!vga_en || be == 0) return 0;
    if (!io) begin
      if (!mem_en) return 0;
      if (a < 32'hA0000 || a > 32'hBFFFF) return 0;
      return !(md && a >= 32'hB0000 && a <= 32'hB7FFF);
    end
    if (!io_en) return 0;
    for (int b = 0; b < 4; b++) begin
      logic [9:0] x;
      x = {a[9:2], 2'(b)};
      if (be[b]) begin
        if ((x >= 10'h3B0 && x <= 10'h3BB) || (x >= 10'h3C0 && x <= 10'h3DF)) v = 1;
        if (ref_mda_io(x)) m = 1;
        if (x >= 10'h3BC && x <= 10'h3BF) h = 1;
      end
    end
    w = (a[15:12] >= io_base) && (a[15:12] <= io_limit);
    return (v || (h && w)) && !(md && m);
  endfunction

  // one request, optionally with a same-cycle write to the monochrome bit
  task automatic do_req(input bit io, input logic [31:0] a, input logic [3:0] be,
                        input bit wr, input bit wd, input string tag);
    bit exp, exp_err;
    @(negedge clk);
    req_valid = 1; req_is_io = io; req_addr = a; req_be = be;
    mdap_wr = wr; mdap_wdata = wd;
    exp = ref_claim(io, a, be, model_mdap);
    exp_err = !vga_en && model_mdap;
    @(negedge clk);
    req_valid = 0; mdap_wr = 0;
    if (wr) model_mdap = wd;
    check(claim_vld, 1'b1, {tag, " R9 vld"});
    check(claim, exp, tag);
    check(cfg_err, exp_err, {tag, " R6 err"});
    if (wr) check(mdap_q, wd, {tag, " R8 write"});
  endtask

  task automatic set_mdap(input bit v);
    @(negedge clk);
    mdap_wr = 1; mdap_wdata = v;
    @(negedge clk);
    mdap_wr = 0; model_mdap = v;
    check(mdap_q, v, "R8 mdap write");
  endtask

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5678));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(claim_vld, 0, "reset R9 vld");
    check(claim, 0, "reset R9 claim");
    check(mdap_q, 0, "reset R8 mdap");
    check(cfg_err, 0, "reset R6 err");

    vga_en = 1; mem_en = 1; io_en = 1; io_base = 4'd2; io_limit = 4'd5;
    do_req(0, 32'hA0000, 4'hF, 0, 0, "R1 A0000");
    do_req(0, 32'hBFFFC, 4'hF, 0, 0, "R1 BFFFC");
    do_req(0, 32'h9FFFC, 4'hF, 0, 0, "R1 below");
    do_req(0, 32'hC0000, 4'hF, 0, 0, "R1 above");
    do_req(0, 32'h100A0000, 4'hF, 0, 0, "R1 high bits");
    do_req(0, 32'hB0000, 4'hF, 0, 0, "R1 mda as vga");
    do_req(0, 32'hB0000, 4'hF, 1, 1, "R8 same-cycle write");
    do_req(0, 32'hB0000, 4'hF, 0, 0, "R2 B0000");
    do_req(0, 32'hB7FFC, 4'hF, 0, 0, "R2 B7FFC");
    do_req(0, 32'hB8000, 4'hF, 0, 0, "R2 B8000");
    do_req(0, 32'hAFFFC, 4'hF, 0, 0, "R2 AFFFC");

    do_req(1, 32'h3B0, 4'hF, 0, 0, "R3 3B0");
    do_req(1, 32'hFFC0, 4'hF, 0, 0, "R3 alias 3C0");
    do_req(1, 32'h3DC, 4'hF, 0, 0, "R3 3DC");
    do_req(1, 32'h3E0, 4'hF, 0, 0, "R3 3E0");
    do_req(1, 32'h3B4, 4'h1, 0, 0, "R4 3B4");
    do_req(1, 32'h3B4, 4'h4, 0, 0, "R4 3B6 only");
    do_req(1, 32'h3B4, 4'h5, 0, 0, "R4 mixed");
    do_req(1, 32'h7FB8, 4'h8, 0, 0, "R4 alias 3BB");
    do_req(1, 32'h3BC, 4'h8, 0, 0, "R4 3BF");
    do_req(1, 32'h33BC, 4'h1, 0, 0, "R5 3BC window mdap");

    set_mdap(0);
    do_req(1, 32'h33BC, 4'hF, 0, 0, "R5 in window");
    do_req(1, 32'h23BC, 4'hF, 0, 0, "R5 base edge");
    do_req(1, 32'h53BC, 4'hF, 0, 0, "R5 limit edge");
    do_req(1, 32'h63BC, 4'hF, 0, 0, "R5 above limit");
    do_req(1, 32'h13BC, 4'hF, 0, 0, "R5 below base");

    io_en = 0;
    do_req(1, 32'h3C0, 4'hF, 0, 0, "R7 io gate");
    io_en = 1; mem_en = 0;
    do_req(0, 32'hA0000, 4'hF, 0, 0, "R7 mem gate");
    mem_en = 1;
    do_req(0, 32'hA0000, 4'h0, 0, 0, "R9 no bytes");
    @(negedge clk);
    check(claim_vld, 0, "R9 idle vld");
    check(claim, 0, "R9 idle claim");

    vga_en = 0;
    do_req(0, 32'hA0000, 4'hF, 0, 0, "R6 vga off");
    set_mdap(1);
    do_req(1, 32'h3C0, 4'hF, 0, 0, "R6 illegal");

    for (int k = 0; k < 3000; k++) begin
      bit io, wr;
      logic [31:0] a;
      vga_en = ($urandom % 5) != 0;
      mem_en = ($urandom % 6) != 0;
      io_en  = ($urandom % 6) != 0;
      io_base = 4'($urandom); io_limit = 4'($urandom);
      io = $urandom % 2;
      if (io) a = {16'h0, 6'($urandom), 10'h3A0 + 10'($urandom % 80)};
      else if ($urandom % 8 == 0) a = $urandom;
      else a = 32'h9F000 + ($urandom % 32'h22000);
      a[1:0] = 2'b00;
      wr = ($urandom % 7) == 0;
      do_req(io, a, 4'($urandom), wr, 1'($urandom), io ? "R3/R4/R5 random io" : "R1/R2 random mem");
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule